// File: doc/BRIEF.md
# Byte-Wide Non-Volatile Data Store Controller

This block connects a small CPU register bus to a byte-organised non-volatile data array of 512 locations. Software loads a 9-bit byte address and, for writes, a data byte through four bus registers. It then starts either a single-byte read or a single-byte write from a control register. The block holds the CPU with a stall output for a fixed number of cycles on each access: four for a read and two for a write. After a write's stall ends, the write finishes on its own.

Writes are self-timed. A busy flag in the control register stays set until a programmable latency has elapsed, so software can poll it before the next byte. A completion interrupt pulse is available. Writes are protected by a two-step unlock: an arm bit must be set first, and a write strobe is only honoured inside a short window after it. A power-down input freezes the bus side, but an in-flight write still completes on schedule.

The array is modelled behaviourally as a register file. Its write delay in clock cycles is a parameter.

Top module: `eep_byte_ctrl`

## Requirements
- R1: Register select 0 holds address bits 7:0, select 1 bit 0 holds address bit 8, select 2 is the data byte, and select 3 is control. The control bits are: bit 0 read trigger (reads as 0), bit 1 write strobe (reads as the busy flag), bit 2 arm, and bit 3 interrupt enable. All 512 locations are reachable, and addresses differing only in bit 8 are distinct.
- R2: A read trigger raises the stall output for exactly 4 cycles, starting in the cycle after the bus write. From the first cycle with stall low, the data register holds the addressed byte.
- R3: An accepted write strobe raises the stall output for exactly 2 cycles. The addressed byte takes the data register value WR_LAT cycles after the strobe.
- R4: The busy flag reads 1 for exactly WR_LAT cycles after an accepted strobe, then reads 0.
- R5: A write strobe without a prior arm has no effect: the busy flag stays 0 and the array is unchanged.
- R6: A strobe is accepted only if its bus write falls 1 to 4 cycles after the arm write. The arm bit reads 1 for those 4 cycles, then reads 0. An accepted strobe clears it at once.
- R7: While busy, read triggers, write strobes, and address and data register writes are ignored.
- R8: If interrupt enable is 1 when a write completes, the interrupt output pulses high for exactly one cycle, the cycle after busy clears. With interrupt enable at 0, it stays low.
- R9: While the power-down input is high, all bus writes are ignored. A write already in flight still completes after WR_LAT cycles.
- R10: After reset, stall, interrupt, busy, arm, interrupt enable, address and data all read 0. The array contents are not reset.
- R11: Bus writes made while the stall output is high are ignored.
- R12: A control write with both the read trigger and the write strobe set performs only the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_down_i | input | 1 | Core power-down; freezes the bus side |
| bus_we_i | input | 1 | Register write enable |
| bus_sel_i | input | 2 | Register select |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Register read data for the selected register |
| stall_o | output | 1 | Holds the CPU during access setup |
| ready_irq_o | output | 1 | One-cycle write-complete pulse |

## Verification
A wrong stall counter shows up the cycle after a trigger, as a stall pulse that is too short or too long. A fault in the write timer shows first as a busy flag that clears one cycle early or late, and then as an interrupt pulse in the wrong cycle. A broken arm window or busy lockout leaks into the array. That only becomes visible at the next read-back of the affected location. The read-back is therefore made right after each protected or ignored operation. Frozen address and data registers are read back through the bus in the cycle after the ignored write.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [1:0] {
    SEL_ALO = 2'd0,
    SEL_AHI = 2'd1,
    SEL_DAT = 2'd2,
    SEL_CTL = 2'd3
  } reg_sel_e;

  localparam int CTL_RD  = 0;
  localparam int CTL_WR  = 1;
  localparam int CTL_ARM = 2;
  localparam int CTL_IEN = 3;
endpackage

// File: rtl/eep_array.sv
module eep_array #(
  parameter int DEPTH = 512,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/eep_regs.sv
module eep_regs import eep_pkg::*; #(
  parameter int AW      = 9,
  parameter int ARM_WIN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we_i,
  input  logic [1:0]    bus_sel_i,
  input  logic [7:0]    bus_wdata_i,
  output logic [7:0]    bus_rdata_o,
  input  logic          pd_i,
  input  logic          stall_i,
  input  logic          busy_i,
  input  logic          rd_load_i,
  input  logic [7:0]    rd_data_i,
  output logic          rd_go_o,
  output logic          wr_go_o,
  output logic          armed_o,
  output logic          irq_en_o,
  output logic [AW-1:0] addr_o,
  output logic [7:0]    data_o
);
  localparam int ACW = $clog2(ARM_WIN + 1);
  localparam int HIW = AW - 8;

  logic [AW-1:0]  addr_q, addr_d;
  logic [7:0]     data_q, data_d;
  logic [ACW-1:0] arm_q, arm_d;
  logic           ien_q, ien_d;
  logic           accept, ctl_wr, reg_open;

  assign armed_o  = (arm_q != '0);
  assign irq_en_o = ien_q;
  assign addr_o   = addr_q;
  assign data_o   = data_q;

  always_comb begin
    accept   = bus_we_i & ~pd_i & ~stall_i;
    ctl_wr   = accept & (bus_sel_i == SEL_CTL);
    reg_open = accept & ~busy_i;
    rd_go_o  = ctl_wr & bus_wdata_i[CTL_RD] & ~busy_i;
    wr_go_o  = ctl_wr & bus_wdata_i[CTL_WR] & ~bus_wdata_i[CTL_RD] & armed_o & ~busy_i;

    addr_d = addr_q;
    if (reg_open && bus_sel_i == SEL_ALO) addr_d[7:0]    = bus_wdata_i;
    if (reg_open && bus_sel_i == SEL_AHI) addr_d[AW-1:8] = bus_wdata_i[HIW-1:0];

    data_d = data_q;
    if (rd_load_i)                             data_d = rd_data_i;
    else if (reg_open && bus_sel_i == SEL_DAT) data_d = bus_wdata_i;

    ien_d = ien_q;
    if (ctl_wr) ien_d = bus_wdata_i[CTL_IEN];

    arm_d = arm_q;
    if (wr_go_o)                            arm_d = '0;
    else if (ctl_wr && bus_wdata_i[CTL_ARM]) arm_d = ACW'(ARM_WIN);
    else if (arm_q != '0)                    arm_d = arm_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      ien_q  <= 1'b0;
      arm_q  <= '0;
    end else begin
      addr_q <= addr_d;
      data_q <= data_d;
      ien_q  <= ien_d;
      arm_q  <= arm_d;
    end
  end

  always_comb begin
    case (bus_sel_i)
      SEL_ALO: bus_rdata_o = addr_q[7:0];
      SEL_AHI: bus_rdata_o = {{(16 - AW){1'b0}}, addr_q[AW-1:8]};
      SEL_DAT: bus_rdata_o = data_q;
      default: bus_rdata_o = {4'b0, ien_q, armed_o, busy_i, 1'b0};
    endcase
  end
endmodule

// File: rtl/eep_seq.sv
module eep_seq #(
  parameter int RD_STALL = 4,
  parameter int WR_STALL = 2,
  parameter int WR_LAT   = 27000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_go_i,
  input  logic wr_go_i,
  input  logic irq_en_i,
  output logic stall_o,
  output logic rd_load_o,
  output logic busy_o,
  output logic commit_o,
  output logic irq_o
);
  localparam int SMAX = (RD_STALL > WR_STALL) ? RD_STALL : WR_STALL;
  localparam int SCW  = $clog2(SMAX + 1);
  localparam int WCW  = $clog2(WR_LAT + 1);

  logic [SCW-1:0] st_q, st_d;
  logic           strd_q, strd_d;
  logic [WCW-1:0] wr_q, wr_d;
  logic           irq_q, irq_d;

  assign stall_o   = (st_q != '0);
  assign rd_load_o = strd_q & (st_q == SCW'(1));
  assign busy_o    = (wr_q != '0);
  assign commit_o  = (wr_q == WCW'(1));
  assign irq_o     = irq_q;

  always_comb begin
    st_d   = st_q;
    strd_d = strd_q;
    if (rd_go_i) begin
      st_d   = SCW'(RD_STALL);
      strd_d = 1'b1;
    end else if (wr_go_i) begin
      st_d   = SCW'(WR_STALL);
      strd_d = 1'b0;
    end else if (stall_o) begin
      st_d   = st_q - 1'b1;
    end

    wr_d = wr_q;
    if (wr_go_i)     wr_d = WCW'(WR_LAT);
    else if (busy_o) wr_d = wr_q - 1'b1;

    irq_d = commit_o & irq_en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      strd_q <= 1'b0;
      wr_q   <= '0;
      irq_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      strd_q <= strd_d;
      wr_q   <= wr_d;
      irq_q  <= irq_d;
    end
  end
endmodule

// File: rtl/eep_byte_ctrl.sv
module eep_byte_ctrl #(
  parameter int DEPTH    = 512,
  parameter int RD_STALL = 4,
  parameter int WR_STALL = 2,
  parameter int ARM_WIN  = 4,
  parameter int WR_LAT   = 27000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_down_i,
  input  logic       bus_we_i,
  input  logic [1:0] bus_sel_i,
  input  logic [7:0] bus_wdata_i,
  output logic [7:0] bus_rdata_o,
  output logic       stall_o,
  output logic       ready_irq_o
);
  localparam int AW = $clog2(DEPTH);

  logic [1:0]    rst_pipe_q;
  logic          rst_sync_n;
  logic          rd_go_w, wr_go_w, armed_w, ien_w;
  logic          busy_w, commit_w, rd_load_w;
  logic [AW-1:0] addr_w;
  logic [7:0]    data_w, arr_rdata_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  eep_regs #(.AW(AW), .ARM_WIN(ARM_WIN)) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .bus_we_i(bus_we_i), .bus_sel_i(bus_sel_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .pd_i(pwr_down_i), .stall_i(stall_o),
    .busy_i(busy_w), .rd_load_i(rd_load_w), .rd_data_i(arr_rdata_w),
    .rd_go_o(rd_go_w), .wr_go_o(wr_go_w), .armed_o(armed_w),
    .irq_en_o(ien_w), .addr_o(addr_w), .data_o(data_w)
  );

  eep_seq #(.RD_STALL(RD_STALL), .WR_STALL(WR_STALL), .WR_LAT(WR_LAT)) u_seq (
    .clk(clk), .rst_n(rst_sync_n),
    .rd_go_i(rd_go_w), .wr_go_i(wr_go_w), .irq_en_i(ien_w),
    .stall_o(stall_o), .rd_load_o(rd_load_w), .busy_o(busy_w),
    .commit_o(commit_w), .irq_o(ready_irq_o)
  );

  eep_array #(.DEPTH(DEPTH), .AW(AW)) u_array (
    .clk(clk), .we_i(commit_w), .addr_i(addr_w),
    .wdata_i(data_w), .rdata_o(arr_rdata_w)
  );
endmodule

// File: rtl/eep_ctrl_checker.sv
module eep_ctrl_checker #(
  parameter int AW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pd,
  input logic          stall,
  input logic          irq,
  input logic          busy,
  input logic          armed,
  input logic          rd_go,
  input logic          wr_go,
  input logic [AW-1:0] addr,
  input logic [7:0]    data
);
  p_rd_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> stall ##1 stall ##1 stall ##1 stall ##1 !stall);

  p_wr_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> stall ##1 stall ##1 !stall);

  p_start_armed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(armed));

  p_frozen_regs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(addr) && $stable(data));

  p_irq_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_irq_on_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(busy) && !busy);

  p_pd_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pd |=> $stable(addr));
endmodule

bind eep_byte_ctrl eep_ctrl_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .pd(pwr_down_i), .stall(stall_o),
  .irq(ready_irq_o), .busy(busy_w), .armed(armed_w), .rd_go(rd_go_w),
  .wr_go(wr_go_w), .addr(addr_w), .data(data_w)
);

// File: tb/eep_byte_ctrl_test.sv
module eep_byte_ctrl_test;
  localparam int LAT = 6;

  logic       clk = 1'b0;
  logic       rst_n, pd, we;
  logic [1:0] sel;
  logic [7:0] wd, rdata;
  logic       stall, irq;

  always #10 clk = ~clk;

  eep_byte_ctrl #(.WR_LAT(LAT)) uut (
    .clk(clk), .rst_n(rst_n), .pwr_down_i(pd), .bus_we_i(we),
    .bus_sel_i(sel), .bus_wdata_i(wd), .bus_rdata_o(rdata),
    .stall_o(stall), .ready_irq_o(irq)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int irq_seen = 0;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [7:0] m_mem [512];
  bit         m_known [512];
  int  m_addr, m_arm, m_st, m_wr;
  logic [7:0] m_data;
  bit  m_dk, m_ien, m_strd, m_irq;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_addr = 0; m_data = 0; m_dk = 1; m_ien = 0; m_arm = 0;
      m_st = 0; m_strd = 0; m_wr = 0; m_irq = 0;
    end else begin
      bit acc, ctl, rdgo, wrgo;
      acc  = we && !pd && (m_st == 0);
      ctl  = acc && sel == 2'd3;
      rdgo = ctl && wd[0] && m_wr == 0;
      wrgo = ctl && wd[1] && !wd[0] && m_arm > 0 && m_wr == 0;
      m_irq = (m_wr == 1) && m_ien;
      if (m_wr == 1) begin m_mem[m_addr] = m_data; m_known[m_addr] = m_dk; end
      if (m_st == 1 && m_strd) begin m_data = m_mem[m_addr]; m_dk = m_known[m_addr]; end
      else if (acc && m_wr == 0 && sel == 2'd2) begin m_data = wd; m_dk = 1; end
      if (acc && m_wr == 0 && sel == 2'd0) m_addr = (m_addr & 256) | int'(wd);
      if (acc && m_wr == 0 && sel == 2'd1) m_addr = (m_addr & 255) | (int'(wd[0]) << 8);
      if (ctl) m_ien = wd[3];
      if (wrgo) m_arm = 0;
      else if (ctl && wd[2]) m_arm = 4;
      else if (m_arm > 0) m_arm--;
      if (rdgo) begin m_st = 4; m_strd = 1; end
      else if (wrgo) begin m_st = 2; m_strd = 0; end
      else if (m_st > 0) m_st--;
      if (wrgo) m_wr = LAT;
      else if (m_wr > 0) m_wr--;
    end
  end

  function automatic logic [7:0] exp_rd();
    case (sel)
      2'd0: return m_addr[7:0];
      2'd1: return {7'b0, m_addr[8]};
      2'd2: return m_data;
      default: return {4'b0, m_ien, m_arm > 0, m_wr > 0, 1'b0};
    endcase
  endfunction

  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      check("R2 R3 stall vs model", stall, m_st > 0);
      check("R8 irq vs model", irq, m_irq);
      if (!(sel == 2'd2 && !m_dk)) check("R1 rdata vs model", rdata, exp_rd());
      if (irq) irq_seen++;
    end
  end

  // stimulus helpers, entered at a falling edge
  task automatic bus_wr(input logic [1:0] s, input logic [7:0] v);
    sel = s; wd = v; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] s, output logic [7:0] v);
    sel = s; #1; v = rdata;
  endtask

  task automatic set_addr(input logic [8:0] a);
    bus_wr(2'd0, a[7:0]);
    bus_wr(2'd1, {7'b0, a[8]});
  endtask

  task automatic wait_idle();
    logic [7:0] c;
    bus_rd(2'd3, c);
    while (stall || c[1]) begin
      @(negedge clk);
      bus_rd(2'd3, c);
    end
  endtask

  task automatic do_read(input logic [8:0] a, output logic [7:0] v);
    set_addr(a);
    bus_wr(2'd3, 8'h01);
    while (stall) @(negedge clk);
    bus_rd(2'd2, v);
  endtask

  task automatic do_write(input logic [8:0] a, input logic [7:0] d, input logic ien);
    set_addr(a);
    bus_wr(2'd2, d);
    bus_wr(2'd3, {4'b0, ien, 3'b100});
    bus_wr(2'd3, {4'b0, ien, 3'b010});
    wait_idle();
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] v, c;
    int ns, nb;
    rst_n = 1'b0; pd = 1'b0; we = 1'b0; sel = 2'd3; wd = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10 reset state
    bus_rd(2'd3, v); check("R10 ctrl after reset", v, 8'h00);
    bus_rd(2'd0, v); check("R10 addr after reset", v, 8'h00);
    bus_rd(2'd2, v); check("R10 data after reset", v, 8'h00);
    check("R10 stall after reset", stall, 1'b0);
    check("R10 irq after reset", irq, 1'b0);

    // R1 full 9-bit addressing
    do_write(9'h1A5, 8'h5C, 1'b1);
    do_write(9'h0A5, 8'h3E, 1'b1);
    do_read(9'h1A5, v); check("R1 high half byte", v, 8'h5C);
    do_read(9'h0A5, v); check("R1 low half byte", v, 8'h3E);
    bus_rd(2'd1, v); check("R1 addr bit8 readback", v, 8'h00);

    // R2 read stall length and data at drop
    set_addr(9'h1A5);
    bus_wr(2'd3, 8'h01);
    ns = 0;
    while (stall) begin ns++; @(negedge clk); end
    check("R2 read stall cycles", ns, 4);
    bus_rd(2'd2, v); check("R2 data when stall drops", v, 8'h5C);

    // R3 R4 R8 write stall, busy length, irq pulse
    set_addr(9'h010);
    bus_wr(2'd2, 8'h99);
    bus_wr(2'd3, 8'h0C);
    irq_seen = 0;
    bus_wr(2'd3, 8'h0A);
    ns = 0; nb = 0;
    forever begin
      bus_rd(2'd3, c);
      if (stall) ns++;
      if (!c[1]) break;
      nb++;
      @(negedge clk);
    end
    check("R3 write stall cycles", ns, 2);
    check("R4 busy cycles", nb, LAT);
    check("R8 irq pulses enabled", irq_seen, 1);
    do_read(9'h010, v); check("R3 written byte", v, 8'h99);

    // R5 lone strobe
    do_write(9'h020, 8'h11, 1'b0);
    bus_wr(2'd2, 8'hEE);
    bus_wr(2'd3, 8'h02);
    bus_rd(2'd3, c); check("R5 lone strobe busy", c[1], 1'b0);
    do_read(9'h020, v); check("R5 array unchanged", v, 8'h11);

    // R6 arm window
    bus_wr(2'd2, 8'h42);
    bus_wr(2'd3, 8'h04);
    bus_rd(2'd3, c); check("R6 arm bit set", c[2], 1'b1);
    repeat (4) @(negedge clk);
    bus_rd(2'd3, c); check("R6 arm expired", c[2], 1'b0);
    bus_wr(2'd3, 8'h02);
    bus_rd(2'd3, c); check("R6 late strobe ignored", c[1], 1'b0);
    bus_wr(2'd3, 8'h04);
    repeat (3) @(negedge clk);
    bus_wr(2'd3, 8'h02);
    bus_rd(2'd3, c); check("R6 strobe in window busy", c[1], 1'b1);
    check("R6 arm cleared by strobe", c[2], 1'b0);
    wait_idle();
    do_read(9'h020, v); check("R6 window write landed", v, 8'h42);

    // R7 lockout while busy
    set_addr(9'h030);
    bus_wr(2'd2, 8'h55);
    bus_wr(2'd3, 8'h04);
    bus_wr(2'd3, 8'h02);
    while (stall) @(negedge clk);
    bus_wr(2'd0, 8'h31);
    bus_wr(2'd2, 8'hAA);
    bus_wr(2'd3, 8'h01);
    check("R7 read trigger ignored", stall, 1'b0);
    bus_rd(2'd0, v); check("R7 addr frozen", v, 8'h30);
    bus_rd(2'd2, v); check("R7 data frozen", v, 8'h55);
    wait_idle();
    do_read(9'h030, v); check("R7 write intact", v, 8'h55);

    // R8 interrupt disabled
    irq_seen = 0;
    do_write(9'h040, 8'h77, 1'b0);
    repeat (2) @(negedge clk);
    check("R8 no irq when disabled", irq_seen, 0);

    // R9 power-down during a write
    set_addr(9'h050);
    bus_wr(2'd2, 8'hC3);
    bus_wr(2'd3, 8'h04);
    bus_wr(2'd3, 8'h02);
    pd = 1'b1;
    nb = 1;
    forever begin
      @(negedge clk);
      bus_rd(2'd3, c);
      if (!c[1]) break;
      nb++;
    end
    check("R9 busy cycles in power-down", nb, LAT);
    bus_wr(2'd0, 8'h77);
    bus_wr(2'd3, 8'h04);
    bus_rd(2'd3, c); check("R9 arm ignored in power-down", c[2], 1'b0);
    pd = 1'b0;
    bus_rd(2'd0, v); check("R9 addr ignored in power-down", v, 8'h50);
    do_read(9'h050, v); check("R9 write completed", v, 8'hC3);

    // R11 writes during stall ignored
    set_addr(9'h1A5);
    bus_wr(2'd3, 8'h01);
    bus_wr(2'd0, 8'h00);
    bus_wr(2'd2, 8'h00);
    while (stall) @(negedge clk);
    bus_rd(2'd0, v); check("R11 addr write in stall", v, 8'hA5);
    bus_rd(2'd2, v); check("R11 data write in stall", v, 8'h5C);

    // R12 read wins over strobe
    set_addr(9'h010);
    bus_wr(2'd3, 8'h04);
    bus_wr(2'd3, 8'h03);
    ns = 0;
    bus_rd(2'd3, c);
    while (stall) begin ns++; @(negedge clk); end
    check("R12 read stall", ns, 4);
    check("R12 no write started", c[1], 1'b0);
    bus_rd(2'd2, v); check("R12 read data", v, 8'h99);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule